// File: doc/BRIEF.md
# Leap-Frog Segmented DAC Decoder

This block turns a 16-bit converter code into the digital controls for a two-stage segmented DAC. The upper bits choose one of 16 segments of a resistor string with 17 nodes. Two coarse tap multiplexers pick the two nodes that bound that segment and pass them to a 12-bit interpolating fine DAC.

The taps are assigned in leap-frog fashion. Tap A only ever lands on even nodes and tap B only on odd nodes. When the code crosses into the next segment, only one tap moves. Which of the two taps is the upper one therefore flips from segment to segment. The block complements the fine code whenever tap A is the upper tap, so that the fine DAC keeps interpolating upward.

All outputs are registered and change together, on the clock edge where the load strobe is high. Between loads they hold. The resistor string and the fine DAC are outside this block.

Top module: `lf_dac_decoder`

## Requirements
- R1: After reset, tap A selects node 0 (`tap_a_sel` = 9'h001), tap B selects node 1 (`tap_b_sel` = 8'h01), `fine_code` is 0 and `a_is_upper` is 0.
- R2: On a rising clock edge with `load` high, all four outputs take the decode of `code`, and are visible after that edge.
- R3: On a rising edge with `load` low, all outputs keep their values, whatever `code` does.
- R4: `tap_a_sel` is one-hot over 9 bits, where bit j enables string node 2j. `tap_b_sel` is one-hot over 8 bits, where bit j enables node 2j+1.
- R5: The segment is k = `code[15:12]`. The two taps sit on nodes k and k+1: tap A on whichever of the two is even, tap B on the odd one.
- R6: `a_is_upper` is 1 exactly when k is odd, that is, when tap A holds node k+1.
- R7: `fine_code` equals `code[11:0]` when k is even, and the bitwise complement of `code[11:0]` when k is odd.
- R8: A load that moves the segment by exactly one (up or down) changes exactly one of `tap_a_sel` and `tap_b_sel`.
- R9: Code 16'h0000 gives node 0 and node 1 with fine 0. Code 16'hFFFF gives tap A on node 16 (`tap_a_sel` bit 8), tap B on node 15 (`tap_b_sel` bit 7) and `fine_code` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Strobe: capture `code` on this edge |
| code | input | 16 | Converter input code |
| tap_a_sel | output | 9 | One-hot enables for the even string nodes |
| tap_b_sel | output | 8 | One-hot enables for the odd string nodes |
| fine_code | output | 12 | Code for the fine DAC, complemented on odd segments |
| a_is_upper | output | 1 | 1 when tap A is the upper node of the segment |

## Verification
Random codes cover every segment with arbitrary low bits, so a tap or polarity error on any segment shows up. Directed walks step through the segments one at a time, upward and then downward. They separate a true leap-frog assignment, where one tap moves per step, from a plain split, where both taps move. The all-zero and all-one codes pin down the end nodes and the complement on the last segment. Loads with the strobe low and a changing code tell a held register apart from a transparent path.

// File: rtl/lf_dac_pkg.sv
package lf_dac_pkg;
  localparam int DEF_CODE_W = 16;
  localparam int DEF_SEG_W  = 4;

  typedef enum logic {
    A_LOWER = 1'b0,
    A_UPPER = 1'b1
  } tap_order_e;
endpackage

// File: rtl/lf_seg_map.sv
module lf_seg_map #(
  parameter int SEG_W = 4,
  localparam int IA_W = SEG_W,
  localparam int IB_W = SEG_W - 1
) (
  input  logic [SEG_W-1:0]       seg,
  output logic [IA_W-1:0]        idx_a,
  output logic [IB_W-1:0]        idx_b,
  output lf_dac_pkg::tap_order_e order
);
  // The even node of {k, k+1} is (k+1)&~1, so its index among the even nodes is (k+1)>>1.
  function automatic logic [IA_W-1:0] even_index(input logic [SEG_W-1:0] k);
    logic [SEG_W:0] t;
    t = {1'b0, k} + 1'b1;
    return t[SEG_W:1];
  endfunction

  // The odd node of {k, k+1} has index k>>1 among the odd nodes.
  function automatic logic [IB_W-1:0] odd_index(input logic [SEG_W-1:0] k);
    return k[SEG_W-1:1];
  endfunction

  always_comb begin
    idx_a = even_index(seg);
    idx_b = odd_index(seg);
    order = seg[0] ? lf_dac_pkg::A_UPPER : lf_dac_pkg::A_LOWER;
  end
endmodule

// File: rtl/lf_onehot.sv
module lf_onehot #(
  parameter int N  = 9,
  parameter int IW = 4
) (
  input  logic [IW-1:0] idx,
  output logic [N-1:0]  sel
);
  for (genvar j = 0; j < N; j++) begin : g_bit
    assign sel[j] = (idx == IW'(j));
  end
endmodule

// File: rtl/lf_fine_fold.sv
module lf_fine_fold #(
  parameter int FINE_W = 12
) (
  input  logic [FINE_W-1:0] lsb,
  input  logic              flip,
  output logic [FINE_W-1:0] fine
);
  for (genvar i = 0; i < FINE_W; i++) begin : g_bit
    assign fine[i] = lsb[i] ^ flip;
  end
endmodule

// File: rtl/lf_dac_decoder.sv
module lf_dac_decoder #(
  parameter int CODE_W = lf_dac_pkg::DEF_CODE_W,
  parameter int SEG_W  = lf_dac_pkg::DEF_SEG_W,
  localparam int FINE_W = CODE_W - SEG_W,
  localparam int NSEG   = 2 ** SEG_W,
  localparam int NA     = NSEG / 2 + 1,
  localparam int NB     = NSEG / 2,
  localparam int IA_W   = SEG_W,
  localparam int IB_W   = SEG_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CODE_W-1:0] code,
  output logic [NA-1:0]     tap_a_sel,
  output logic [NB-1:0]     tap_b_sel,
  output logic [FINE_W-1:0] fine_code,
  output logic              a_is_upper
);
  import lf_dac_pkg::*;

  logic [SEG_W-1:0]  seg_in;
  logic [FINE_W-1:0] lsb_in;
  logic [IA_W-1:0]   idx_a;
  logic [IB_W-1:0]   idx_b;
  tap_order_e        order;
  logic [NA-1:0]     sel_a_d;
  logic [NB-1:0]     sel_b_d;
  logic [FINE_W-1:0] fine_d;
  logic [SEG_W-1:0]  seg_q;

  assign seg_in = code[CODE_W-1:FINE_W];
  assign lsb_in = code[FINE_W-1:0];

  lf_seg_map #(.SEG_W(SEG_W)) u_map (
    .seg(seg_in), .idx_a(idx_a), .idx_b(idx_b), .order(order)
  );

  lf_onehot #(.N(NA), .IW(IA_W)) u_dec_a (.idx(idx_a), .sel(sel_a_d));
  lf_onehot #(.N(NB), .IW(IB_W)) u_dec_b (.idx(idx_b), .sel(sel_b_d));

  lf_fine_fold #(.FINE_W(FINE_W)) u_fold (
    .lsb(lsb_in), .flip(order == A_UPPER), .fine(fine_d)
  );

  // Output register: every field is loaded on the same edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tap_a_sel  <= NA'(1);
      tap_b_sel  <= NB'(1);
      fine_code  <= '0;
      a_is_upper <= 1'b0;
      seg_q      <= '0;
    end else if (load) begin
      tap_a_sel  <= sel_a_d;
      tap_b_sel  <= sel_b_d;
      fine_code  <= fine_d;
      a_is_upper <= (order == A_UPPER);
      seg_q      <= seg_in;
    end
  end

  // Event: this load moves the segment by exactly one.
  logic [SEG_W:0] seg_in_x, seg_q_x;
  logic           seg_step;
  assign seg_in_x = {1'b0, seg_in};
  assign seg_q_x  = {1'b0, seg_q};
  assign seg_step = load && ((seg_in_x == seg_q_x + 1'b1) || (seg_q_x == seg_in_x + 1'b1));

  AST_A_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tap_a_sel) == 1); // R4
  AST_B_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(tap_b_sel) == 1); // R4
  AST_ADJACENT: assert property (@(posedge clk) disable iff (!rst_n)
    tap_a_sel == (a_is_upper ? NA'({tap_b_sel, 1'b0}) : NA'({1'b0, tap_b_sel}))); // R5
  AST_UPPER_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> a_is_upper == $past(code[FINE_W])); // R6
  AST_FINE_FOLD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> fine_code == ($past(code[FINE_W]) ? ~$past(code[FINE_W-1:0]) : $past(code[FINE_W-1:0]))); // R7
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(tap_a_sel) && $stable(tap_b_sel) && $stable(fine_code) && $stable(a_is_upper))); // R3
  AST_LEAP_FROG: assert property (@(posedge clk) disable iff (!rst_n)
    seg_step |=> ($stable(tap_a_sel) != $stable(tap_b_sel))); // R8
endmodule

// File: tb/sim_lf_dac_decoder.sv
`timescale 1ns/1ps
module sim_lf_dac_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load = 1'b0;
  logic [15:0] code = '0;
  logic [8:0]  tap_a_sel;
  logic [7:0]  tap_b_sel;
  logic [11:0] fine_code;
  logic        a_is_upper;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  lf_dac_decoder u0 (
    .clk(clk), .rst_n(rst_n), .load(load), .code(code),
    .tap_a_sel(tap_a_sel), .tap_b_sel(tap_b_sel),
    .fine_code(fine_code), .a_is_upper(a_is_upper)
  );

  // Expected decode, built by walking the string nodes.
  function automatic logic [8:0] want_a(input logic [15:0] c);
    int k = int'(c[15:12]);
    logic [8:0] v = '0;
    for (int n = 0; n <= 16; n++)
      if ((n == k || n == k + 1) && (n % 2 == 0)) v[n/2] = 1'b1;
    return v;
  endfunction
  function automatic logic [7:0] want_b(input logic [15:0] c);
    int k = int'(c[15:12]);
    logic [7:0] v = '0;
    for (int n = 0; n <= 16; n++)
      if ((n == k || n == k + 1) && (n % 2 == 1)) v[(n-1)/2] = 1'b1;
    return v;
  endfunction
  function automatic logic want_up(input logic [15:0] c);
    return (int'(c[15:12]) % 2) == 1;
  endfunction
  function automatic logic [11:0] want_fine(input logic [15:0] c);
    return want_up(c) ? (12'hFFF - c[11:0]) : c[11:0];
  endfunction

  task automatic check(input string tag, input logic [8:0] ea, input logic [7:0] eb,
                       input logic [11:0] ef, input logic eu);
    total++;
    if (tap_a_sel !== ea || tap_b_sel !== eb || fine_code !== ef || a_is_upper !== eu) begin
      bad++;
      $display("FAIL %s: got a=%h b=%h fine=%h up=%b, expected a=%h b=%h fine=%h up=%b",
               tag, tap_a_sel, tap_b_sel, fine_code, a_is_upper, ea, eb, ef, eu);
    end
  endtask

  task automatic check_code(input string tag, input logic [15:0] c);
    check(tag, want_a(c), want_b(c), want_fine(c), want_up(c));
  endtask

  // Inputs change at the falling edge; outputs are read one full cycle later.
  task automatic do_load(input logic [15:0] c);
    @(negedge clk);
    code = c;
    load = 1'b1;
    @(negedge clk);
    load = 1'b0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got no finish, expected finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] c, prev;
    logic [8:0]  pa;
    logic [7:0]  pb;
    void'($urandom(32'h5EED_0417));
    repeat (3) @(negedge clk);
    check("R1 reset", 9'h001, 8'h01, 12'h000, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", 9'h001, 8'h01, 12'h000, 1'b0);

    // R9 end codes
    do_load(16'h0000); check_code("R9 zero code", 16'h0000);
    check("R9 zero literal", 9'h001, 8'h01, 12'h000, 1'b0);
    do_load(16'hFFFF);
    check("R9 full code", 9'h100, 8'h80, 12'h000, 1'b1);

    // R6 R7 directed: odd segment with a known fine pattern
    do_load(16'h3A5C); check("R7 odd segment", 9'h004, 8'h02, 12'h5A3, 1'b1);
    do_load(16'h4A5C); check("R6 even segment", 9'h004, 8'h04, 12'hA5C, 1'b0);

    // R3 hold: strobe low, code wanders
    prev = 16'h4A5C;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      code = 16'($urandom());
      @(negedge clk);
      check("R3 hold", want_a(prev), want_b(prev), want_fine(prev), want_up(prev));
    end

    // R8 leap-frog walk up then down
    do_load(16'h0123);
    for (int k = 1; k < 16; k++) begin
      pa = tap_a_sel; pb = tap_b_sel;
      c = {4'(k), 12'($urandom())};
      do_load(c);
      check_code("R5 walk up", c);
      total++;
      if (((pa != tap_a_sel) ? 1 : 0) + ((pb != tap_b_sel) ? 1 : 0) != 1) begin
        bad++;
        $display("FAIL R8 step up to %0d: got a=%h->%h b=%h->%h, expected one tap moved",
                 k, pa, tap_a_sel, pb, tap_b_sel);
      end
    end
    for (int k = 14; k >= 0; k--) begin
      pa = tap_a_sel; pb = tap_b_sel;
      c = {4'(k), 12'($urandom())};
      do_load(c);
      check_code("R5 walk down", c);
      total++;
      if (((pa != tap_a_sel) ? 1 : 0) + ((pb != tap_b_sel) ? 1 : 0) != 1) begin
        bad++;
        $display("FAIL R8 step down to %0d: got a=%h->%h b=%h->%h, expected one tap moved",
                 k, pa, tap_a_sel, pb, tap_b_sel);
      end
    end

    // R2 R4 random loads, some back to back
    for (int i = 0; i < 300; i++) begin
      c = 16'($urandom());
      if (i % 3 == 0) begin
        @(negedge clk);
        code = c;
        load = 1'b1;
        @(negedge clk);
        check_code("R2 back-to-back", c);
        load = 1'b0;
      end else begin
        do_load(c);
        check_code("R4 random", c);
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule